// File: doc/BRIEF.md
# Dual-Port RAM with Address-Collision Busy Arbitration

This block is a two-port static RAM with a synchronous interface. Each side, left and right, has an active-low select, an address, a write strobe, write data and registered read data. When both sides select the same location in the same cycle, an arbiter picks one side to keep access. The other side receives an active-low busy flag, and its write is suppressed. The arbiter's decision uses only the selects and the addresses. Whether an access reads or writes never affects it.

A mode input selects one of two roles. In master mode the block arbitrates and drives its busy outputs. In slave mode the busy outputs stay high and are not driven. Each busy input then acts only as a write inhibit for its own side. To build a wider word, one master holds one byte lane and one or more slaves hold the other lanes. The master's busy outputs feed the slaves' busy inputs, so the whole word is written by one side only.

The ports are shown at the default depth. For an 8K x 8 array, set `ADDR_W` to 13. Busy is combinational from the current cycle's selects and addresses. Writes commit at the rising clock edge, after the decision has settled.

Top module: `dp_ram_arb`

## Requirements
- R1: The storage holds 2**ADDR_W words of DATA_W bits. Each side reads and writes independently in the same cycle. Read data is registered and appears the cycle after a selected access. A write and a read to the same location in one cycle return the old contents. Reset clears both read data outputs to 0.
- R2: In master mode, both busy outputs are high unless both selects are low and both addresses are equal.
- R3: In master mode, a collision (both selects low, addresses equal) pulls exactly one busy output low, never both.
- R4: A collision in which neither side was selected at that address in the previous cycle drives the right busy output low (the left side wins the tie).
- R5: If one side was already selected at an address in the previous cycle and the other side moves onto it, the later side is busy. This holds every cycle while the collision persists at that address.
- R6: The write strobes have no effect on which side is busy. Read/read, read/write and write/write collisions are arbitrated identically.
- R7: A write from a side flagged busy leaves the stored word fully unchanged. A busy side still reads the stored data.
- R8: In slave mode, both busy outputs are held high. A low busy input blocks every write from that side, and a high busy input leaves that side working as a normal RAM port.
- R9: In master mode, the busy inputs are ignored. A low busy input does not block writes.
- R10: While a side's select is high, its read data output holds its previous value.
- R11: In slave mode, if both sides write the same location in one cycle with busy inputs high, the left side's data is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| master_i | input | 1 | 1 = master (arbitrate), 0 = slave (busy is write inhibit) |
| l_cs_ni | input | 1 | Left select, active low |
| l_addr_i | input | ADDR_W | Left address |
| l_we_i | input | 1 | Left write strobe, active high |
| l_wdata_i | input | DATA_W | Left write data |
| l_rdata_o | output | DATA_W | Left registered read data |
| l_busy_ni | input | 1 | Left write inhibit in slave mode, active low |
| l_busy_no | output | 1 | Left busy in master mode, active low; high in slave mode |
| r_cs_ni | input | 1 | Right select, active low |
| r_addr_i | input | ADDR_W | Right address |
| r_we_i | input | 1 | Right write strobe, active high |
| r_wdata_i | input | DATA_W | Right write data |
| r_rdata_o | output | DATA_W | Right registered read data |
| r_busy_ni | input | 1 | Right write inhibit in slave mode, active low |
| r_busy_no | output | 1 | Right busy in master mode, active low; high in slave mode |

## Verification
The assertions check four rules on every cycle:
- busy is quiet without a collision;
- the two busy outputs are mutually exclusive;
- a fresh tie goes to the left side and a winning side stays the winner while the collision persists;
- slave mode leaves busy undriven, and read data holds while a side is deselected.

The contents of storage can only be shown by the bench's scenarios, which write and read back through the ports. These scenarios cover:
- blocked writes that leave a word intact;
- master mode ignoring its busy inputs;
- the slave's forced inhibit;
- the slave's left-wins rule.

In the bench, a master and a slave share the busy lines as two byte lanes. The bench checks that a colliding write never leaves a word made of one side's low byte and the other side's high byte.

// File: rtl/dp_ram_arb_pkg.sv
package dp_ram_arb_pkg;
  localparam int unsigned NPORT = 2;
  localparam int unsigned LEFT  = 0;
  localparam int unsigned RIGHT = 1;

  typedef enum logic {
    SIDE_L = 1'b0,
    SIDE_R = 1'b1
  } side_e;
endpackage

// File: rtl/dp_ram_arb_track.sv
// Remembers where a side was selected in the previous cycle.
module dp_ram_arb_track #(
  parameter int unsigned ADDR_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              held_o,
  output logic [ADDR_W-1:0] held_addr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_o      <= 1'b0;
      held_addr_o <= '0;
    end else begin
      held_o      <= !cs_ni;
      held_addr_o <= addr_i;
    end
  end
endmodule

// File: rtl/dp_ram_arb_judge.sv
// Collision detect and loser selection; ignores write strobes.
module dp_ram_arb_judge
  import dp_ram_arb_pkg::*;
#(
  parameter int unsigned ADDR_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NPORT-1:0]  cs_ni,
  input  logic [ADDR_W-1:0] addr_i      [NPORT],
  input  logic [NPORT-1:0]  held_i,
  input  logic [ADDR_W-1:0] held_addr_i [NPORT],
  output logic [NPORT-1:0]  lose_o
);
  logic  coll;
  logic  keep;
  logic  l_first;
  logic  r_first;
  side_e loser;
  logic  coll_q;
  side_e loser_q;

  assign coll    = !cs_ni[LEFT] && !cs_ni[RIGHT] && (addr_i[LEFT] == addr_i[RIGHT]);
  assign keep    = coll_q && held_i[LEFT] && (held_addr_i[LEFT] == addr_i[LEFT]);
  assign l_first = held_i[LEFT]  && (held_addr_i[LEFT]  == addr_i[LEFT]);
  assign r_first = held_i[RIGHT] && (held_addr_i[RIGHT] == addr_i[RIGHT]);

  always_comb begin
    if (keep)                    loser = loser_q;
    else if (r_first && !l_first) loser = SIDE_L;
    else                          loser = SIDE_R;
  end

  assign lose_o[LEFT]  = coll && (loser == SIDE_L);
  assign lose_o[RIGHT] = coll && (loser == SIDE_R);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      coll_q  <= 1'b0;
      loser_q <= SIDE_R;
    end else begin
      coll_q  <= coll;
      loser_q <= loser;
    end
  end
endmodule

// File: rtl/dp_ram_arb_store.sv
// Two-port array; right written first so left wins a same-address double write.
module dp_ram_arb_store
  import dp_ram_arb_pkg::*;
#(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NPORT-1:0]  cs_ni,
  input  logic [ADDR_W-1:0] addr_i  [NPORT],
  input  logic [NPORT-1:0]  wr_i,
  input  logic [DATA_W-1:0] wdata_i [NPORT],
  output logic [DATA_W-1:0] rdata_o [NPORT]
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_i[RIGHT]) mem_q[addr_i[RIGHT]] <= wdata_i[RIGHT];
    if (wr_i[LEFT])  mem_q[addr_i[LEFT]]  <= wdata_i[LEFT];
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_rd
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         rdata_o[p] <= '0;
      else if (!cs_ni[p])  rdata_o[p] <= mem_q[addr_i[p]];
    end
  end
endmodule

// File: rtl/dp_ram_arb.sv
module dp_ram_arb
  import dp_ram_arb_pkg::*;
#(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              master_i,
  input  logic              l_cs_ni,
  input  logic [ADDR_W-1:0] l_addr_i,
  input  logic              l_we_i,
  input  logic [DATA_W-1:0] l_wdata_i,
  output logic [DATA_W-1:0] l_rdata_o,
  input  logic              l_busy_ni,
  output logic              l_busy_no,
  input  logic              r_cs_ni,
  input  logic [ADDR_W-1:0] r_addr_i,
  input  logic              r_we_i,
  input  logic [DATA_W-1:0] r_wdata_i,
  output logic [DATA_W-1:0] r_rdata_o,
  input  logic              r_busy_ni,
  output logic              r_busy_no
);
  logic [NPORT-1:0]  cs_n;
  logic [NPORT-1:0]  we;
  logic [NPORT-1:0]  busy_in_n;
  logic [ADDR_W-1:0] addr      [NPORT];
  logic [DATA_W-1:0] wdata     [NPORT];
  logic [DATA_W-1:0] rdata     [NPORT];
  logic [NPORT-1:0]  held;
  logic [ADDR_W-1:0] held_addr [NPORT];
  logic [NPORT-1:0]  lose;
  logic [NPORT-1:0]  inhibit;
  logic [NPORT-1:0]  wr;

  assign cs_n      = {r_cs_ni, l_cs_ni};
  assign we        = {r_we_i, l_we_i};
  assign busy_in_n = {r_busy_ni, l_busy_ni};
  assign addr[LEFT]   = l_addr_i;
  assign addr[RIGHT]  = r_addr_i;
  assign wdata[LEFT]  = l_wdata_i;
  assign wdata[RIGHT] = r_wdata_i;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    dp_ram_arb_track #(.ADDR_W(ADDR_W)) u_track (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .cs_ni       (cs_n[p]),
      .addr_i      (addr[p]),
      .held_o      (held[p]),
      .held_addr_o (held_addr[p])
    );
    // master: own arbitration gates the write; slave: external busy does
    assign inhibit[p] = master_i ? lose[p] : !busy_in_n[p];
    assign wr[p]      = !cs_n[p] && we[p] && !inhibit[p];
  end

  dp_ram_arb_judge #(.ADDR_W(ADDR_W)) u_judge (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cs_ni       (cs_n),
    .addr_i      (addr),
    .held_i      (held),
    .held_addr_i (held_addr),
    .lose_o      (lose)
  );

  dp_ram_arb_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cs_ni   (cs_n),
    .addr_i  (addr),
    .wr_i    (wr),
    .wdata_i (wdata),
    .rdata_o (rdata)
  );

  assign l_rdata_o = rdata[LEFT];
  assign r_rdata_o = rdata[RIGHT];
  assign l_busy_no = !(master_i && lose[LEFT]);
  assign r_busy_no = !(master_i && lose[RIGHT]);
endmodule

// File: rtl/dp_ram_arb_chk.sv
module dp_ram_arb_chk #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              master_i,
  input logic              l_cs_ni,
  input logic [ADDR_W-1:0] l_addr_i,
  input logic [DATA_W-1:0] l_rdata_o,
  input logic              l_busy_no,
  input logic              r_cs_ni,
  input logic [ADDR_W-1:0] r_addr_i,
  input logic [DATA_W-1:0] r_rdata_o,
  input logic              r_busy_no
);
  logic hit;
  assign hit = !l_cs_ni && !r_cs_ni && (l_addr_i == r_addr_i);

  AST_QUIET_NO_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_i && !hit) |-> (l_busy_no && r_busy_no)); // R2
  AST_ONE_LOSER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    master_i |-> (l_busy_no || r_busy_no)); // R3
  AST_HIT_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_i && hit) |-> (!l_busy_no || !r_busy_no)); // R3
  AST_TIE_LEFT_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_i && hit && $past(l_cs_ni) && $past(r_cs_ni)) |-> !r_busy_no); // R4
  AST_STICKY_RIGHT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_i && hit && $stable(l_addr_i) && $past(rst_ni) && $past(hit) && $past(!r_busy_no))
    |-> !r_busy_no); // R5
  AST_STICKY_LEFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_i && hit && $stable(l_addr_i) && $past(rst_ni) && $past(hit) && $past(!l_busy_no))
    |-> !l_busy_no); // R5
  AST_SLAVE_UNDRIVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !master_i |-> (l_busy_no && r_busy_no)); // R8
  AST_L_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    l_cs_ni |=> $stable(l_rdata_o)); // R10
  AST_R_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    r_cs_ni |=> $stable(r_rdata_o)); // R10
endmodule

bind dp_ram_arb dp_ram_arb_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .master_i  (master_i),
  .l_cs_ni   (l_cs_ni),
  .l_addr_i  (l_addr_i),
  .l_rdata_o (l_rdata_o),
  .l_busy_no (l_busy_no),
  .r_cs_ni   (r_cs_ni),
  .r_addr_i  (r_addr_i),
  .r_rdata_o (r_rdata_o),
  .r_busy_no (r_busy_no)
);

// File: tb/dp_ram_arb_test.sv
module dp_ram_arb_test;
  localparam int unsigned AW    = 10;
  localparam int unsigned DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          l_cs_n = 1'b1, r_cs_n = 1'b1, l_we = 1'b0, r_we = 1'b0;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic [15:0]   l_wd = '0, r_wd = '0;
  logic [7:0]    m_l_rd, m_r_rd, s_l_rd, s_r_rd;
  logic          m_l_bz, m_r_bz, s_l_bz, s_r_bz;
  logic          m_l_bzi = 1'b1, m_r_bzi = 1'b1;
  logic          frc = 1'b0, frc_l = 1'b1, frc_r = 1'b1;
  logic          s_l_bzi, s_r_bzi;

  assign s_l_bzi = frc ? frc_l : m_l_bz;
  assign s_r_bzi = frc ? frc_r : m_r_bz;

  // low byte lane: master
  dp_ram_arb #(.ADDR_W(AW), .DATA_W(8)) uut (
    .clk_i(clk), .rst_ni(rst_n), .master_i(1'b1),
    .l_cs_ni(l_cs_n), .l_addr_i(l_addr), .l_we_i(l_we), .l_wdata_i(l_wd[7:0]),
    .l_rdata_o(m_l_rd), .l_busy_ni(m_l_bzi), .l_busy_no(m_l_bz),
    .r_cs_ni(r_cs_n), .r_addr_i(r_addr), .r_we_i(r_we), .r_wdata_i(r_wd[7:0]),
    .r_rdata_o(m_r_rd), .r_busy_ni(m_r_bzi), .r_busy_no(m_r_bz)
  );

  // high byte lane: slave fed by master busy
  dp_ram_arb #(.ADDR_W(AW), .DATA_W(8)) u_slave (
    .clk_i(clk), .rst_ni(rst_n), .master_i(1'b0),
    .l_cs_ni(l_cs_n), .l_addr_i(l_addr), .l_we_i(l_we), .l_wdata_i(l_wd[15:8]),
    .l_rdata_o(s_l_rd), .l_busy_ni(s_l_bzi), .l_busy_no(s_l_bz),
    .r_cs_ni(r_cs_n), .r_addr_i(r_addr), .r_we_i(r_we), .r_wdata_i(r_wd[15:8]),
    .r_rdata_o(s_r_rd), .r_busy_ni(s_r_bzi), .r_busy_no(s_r_bz)
  );

  typedef struct {
    bit          side;
    logic [15:0] exp;
    string       req;
  } item_t;

  item_t       q[$];
  logic [7:0]  ref_lo[DEPTH];
  logic [7:0]  ref_hi[DEPTH];
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;
  bit          p_lv = 0, p_rv = 0, p_coll = 0, p_lose_l = 0;
  logic [AW-1:0] p_la = '0, p_ra = '0;
  logic [15:0] last_l = '0, last_r = '0;

  task automatic chk(input logic [15:0] act, input logic [15:0] exp,
                     input string req, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  // driver: applies one cycle, checks busy, queues read expectations
  task automatic step(input bit la, input logic [AW-1:0] lad, input bit lw, input logic [15:0] lwd,
                      input bit ra, input logic [AW-1:0] rad, input bit rw, input logic [15:0] rwd,
                      input string req);
    bit coll, lose_l, el_bz, er_bz, sl, sr;
    item_t it;
    @(negedge clk);
    l_cs_n = !la; l_addr = lad; l_we = lw; l_wd = lwd;
    r_cs_n = !ra; r_addr = rad; r_we = rw; r_wd = rwd;
    coll = la && ra && (lad == rad);
    if (p_coll && p_lv && p_la == lad)                   lose_l = p_lose_l;
    else if (p_rv && p_ra == rad && !(p_lv && p_la == lad)) lose_l = 1'b1;
    else                                                  lose_l = 1'b0;
    el_bz = !(coll && lose_l);
    er_bz = !(coll && !lose_l);
    #1;
    chk({15'd0, m_l_bz}, {15'd0, el_bz}, req, "master left busy");
    chk({15'd0, m_r_bz}, {15'd0, er_bz}, req, "master right busy");
    chk({14'd0, s_l_bz, s_r_bz}, 16'h0003, "R8", "slave busy outputs");
    if (la) last_l = {ref_hi[lad], ref_lo[lad]};
    if (ra) last_r = {ref_hi[rad], ref_lo[rad]};
    it.side = 1'b0; it.exp = last_l; it.req = req; q.push_back(it);
    it.side = 1'b1; it.exp = last_r; it.req = req; q.push_back(it);
    sl = frc ? frc_l : el_bz;
    sr = frc ? frc_r : er_bz;
    if (ra && rw && er_bz) ref_lo[rad] = rwd[7:0];
    if (ra && rw && sr)    ref_hi[rad] = rwd[15:8];
    if (la && lw && el_bz) ref_lo[lad] = lwd[7:0];
    if (la && lw && sl)    ref_hi[lad] = lwd[15:8];
    p_lv = la; p_la = lad; p_rv = ra; p_ra = rad;
    p_coll = coll; p_lose_l = lose_l;
  endtask

  // monitor: compares registered read data one edge after the request
  always @(posedge clk) begin
    #1;
    while (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      if (it.side) chk({s_r_rd, m_r_rd}, it.exp, it.req, "right rdata");
      else         chk({s_l_rd, m_l_rd}, it.exp, it.req, "left rdata");
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk({m_l_rd, m_r_rd}, 16'h0000, "R1", "reset rdata master");
    chk({s_l_rd, s_r_rd}, 16'h0000, "R1", "reset rdata slave");
    chk({14'd0, m_l_bz, m_r_bz}, 16'h0003, "R2", "reset busy");

    // R1: fill with independent simultaneous writes, then read back
    for (int i = 0; i < 8; i++)
      step(1, AW'(i), 1, 16'h1000 + 16'(i * 16'h0111), 1, AW'(i + 8), 1, 16'h2000 + 16'(i * 16'h0101), "R1");
    for (int i = 0; i < 8; i++)
      step(1, AW'(i + 8), 0, 16'h0, 1, AW'(i), 0, 16'h0, "R1");
    // R1: read-first on same-port write
    step(1, 10'd3, 1, 16'hBEEF, 0, 10'd0, 0, 16'h0, "R1");
    step(1, 10'd3, 0, 16'h0, 0, 10'd0, 0, 16'h0, "R1");
    // R10: idle, outputs hold
    step(0, 10'd0, 0, 16'h0, 0, 10'd0, 0, 16'h0, "R10");
    step(0, 10'd5, 1, 16'hFFFF, 0, 10'd6, 1, 16'hFFFF, "R10");

    // R4 and R7: simultaneous write/write tie, no split word
    step(1, 10'd20, 1, 16'hA55A, 1, 10'd20, 1, 16'h3CC3, "R4");
    step(1, 10'd20, 0, 16'h0, 0, 10'd0, 0, 16'h0, "R7");

    // R5: left holds 4, right arrives writing and stays busy
    step(1, 10'd4, 0, 16'h0, 1, 10'd9, 0, 16'h0, "R5");
    step(1, 10'd4, 0, 16'h0, 1, 10'd4, 1, 16'h7777, "R5");
    step(1, 10'd4, 0, 16'h0, 1, 10'd4, 1, 16'h6666, "R5");
    step(0, 10'd0, 0, 16'h0, 1, 10'd4, 0, 16'h0, "R7");
    // R5 and R7: right holds 6, left arrives writing, is blocked but reads
    step(0, 10'd0, 0, 16'h0, 1, 10'd6, 0, 16'h0, "R5");
    step(1, 10'd6, 1, 16'h9999, 1, 10'd6, 0, 16'h0, "R5");
    step(1, 10'd6, 1, 16'h8888, 1, 10'd6, 0, 16'h0, "R7");
    step(1, 10'd6, 0, 16'h0, 0, 10'd0, 0, 16'h0, "R7");

    // R6: read/read, read/write, write/read ties all go the same way
    step(0, 10'd0, 0, 16'h0, 0, 10'd0, 0, 16'h0, "R6");
    step(1, 10'd7, 0, 16'h0, 1, 10'd7, 0, 16'h0, "R6");
    step(0, 10'd0, 0, 16'h0, 0, 10'd0, 0, 16'h0, "R6");
    step(1, 10'd7, 0, 16'h0, 1, 10'd7, 1, 16'h4242, "R6");
    step(0, 10'd0, 0, 16'h0, 0, 10'd0, 0, 16'h0, "R6");
    step(1, 10'd7, 1, 16'h5151, 1, 10'd7, 0, 16'h0, "R6");
    step(1, 10'd7, 0, 16'h0, 0, 10'd0, 0, 16'h0, "R6");

    // R9: master ignores its busy inputs
    m_l_bzi = 1'b0; m_r_bzi = 1'b0;
    step(1, 10'd30, 1, 16'h1234, 1, 10'd31, 1, 16'h5678, "R9");
    step(1, 10'd31, 0, 16'h0, 1, 10'd30, 0, 16'h0, "R9");
    m_l_bzi = 1'b1; m_r_bzi = 1'b1;

    // R8: forced inhibit on slave left lane blocks only its high byte
    frc = 1'b1; frc_l = 1'b0; frc_r = 1'b1;
    step(1, 10'd40, 1, 16'hCAFE, 1, 10'd41, 1, 16'hD00D, "R8");
    step(1, 10'd41, 0, 16'h0, 1, 10'd40, 0, 16'h0, "R8");
    frc_l = 1'b1;
    step(1, 10'd40, 1, 16'hFACE, 0, 10'd0, 0, 16'h0, "R8");
    step(1, 10'd40, 0, 16'h0, 0, 10'd0, 0, 16'h0, "R8");

    // R11: slave, both lanes enabled, same-address double write
    step(0, 10'd0, 0, 16'h0, 0, 10'd0, 0, 16'h0, "R11");
    step(1, 10'd50, 1, 16'hABCD, 1, 10'd50, 1, 16'h1357, "R11");
    step(1, 10'd50, 0, 16'h0, 0, 10'd0, 0, 16'h0, "R11");
    frc = 1'b0;

    step(0, 10'd0, 0, 16'h0, 0, 10'd0, 0, 16'h0, "R10");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule